// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the bit-timing layer of a single-master I2C controller. A sequencer above it issues one bus primitive at a time: a bus recovery, a START condition, a STOP condition, a byte transmit with acknowledge sampling, or a byte receive that ends with an acknowledge bit the master chooses. The engine moves the two open-drain lines through the phases of that primitive. It then returns the received byte and an acknowledge level together with a single-cycle completion pulse.

All phases are measured in delay units. One unit is a number of system clocks taken from a prescale input, which the engine captures when it accepts a command. Both line outputs are pull-low enables: 1 pulls the wire low and 0 releases it. The SDA wire level passes through a two-flop synchronizer before any sampling. Because of this, any command that samples SDA needs a unit of at least two clocks. Arbitration, slave clock stretching, slave mode and transaction sequencing are left to other blocks.

Top module: `i2cBitEngine`

## Requirements
- R1: After reset, sclPull and sdaPull are 0, cmdReady is 1 and doneValid is 0.
- R2: The engine accepts a command in a cycle where cmdValid and cmdReady are both 1. cmdReady stays 0 from the cycle after acceptance until the cycle in which doneValid is 1. In that cycle cmdReady is 1 again.
- R3: One delay unit is L clocks, where L is the prescale value captured at acceptance and a value of 0 counts as 1. Line changes occur only at unit boundaries. doneValid rises N*L clocks after the accepting edge, where N is the unit count of the command.
- R4: cmdCode 2 (START) runs in 4 units. In order the units are: hold, release SDA, release SCL, pull SDA. This produces one SDA fall while SCL is high and leaves SCL released and SDA pulled.
- R5: cmdCode 3 (STOP) runs in 4 units. In order the units are: pull SCL, pull SDA, release SCL, release SDA. This produces one SDA rise while SCL is high and leaves both lines released.
- R6: cmdCode 1 (recovery) runs in 40 units. It gives nine SCL pulses with SDA released, each pulse low for 2 units and high for 2 units. A STOP follows, so exactly one stop condition and no start condition appear.
- R7: cmdCode 4 (transmit) sends cmdByte MSB first over 8 SCL pulses. SDA changes only while SCL is low, and each SCL high phase lasts 2 units.
- R8: The transmit has a ninth SCL pulse with SDA released. The SDA level sampled at the end of that high phase is returned on ackLevel (0 = acknowledged, 1 = not acknowledged). The whole transmit takes 37 units.
- R9: cmdCode 5 (receive) releases SDA and clocks in 8 bits MSB first. Each bit is sampled one unit after the SCL rising edge, each high phase lasts 2 units, and the byte is returned on rxByte.
- R10: On the ninth receive pulse the master drives cmdAck on SDA (0 pulls low, 1 releases). ackLevel returns that value, and the receive takes 29 units.
- R11: doneValid is high for exactly one cycle per command. rxByte and ackLevel are valid in that cycle.
- R12: Any other cmdCode completes after 1 unit without moving either line and with ackLevel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| prescale | input | PRESC_W | Clocks per delay unit, captured at acceptance |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle and able to accept |
| cmdCode | input | 3 | Primitive select |
| cmdByte | input | DATA_W | Byte to transmit |
| cmdAck | input | 1 | Acknowledge level to send after a receive |
| doneValid | output | 1 | One-cycle completion pulse |
| rxByte | output | DATA_W | Received byte |
| ackLevel | output | 1 | Sampled or sent acknowledge level |
| sdaIn | input | 1 | Level of the SDA wire |
| sclPull | output | 1 | 1 pulls SCL low |
| sdaPull | output | 1 | 1 pulls SDA low |

## Verification
A phase or bit counter that slips shows up at the SCL pin within one unit, because a high phase is then longer or shorter than two units. The same slip also moves the completion pulse by whole multiples of L. A wrong shift-register or acknowledge state appears as a wrong SDA level at an SCL rising edge, or as a wrong byte or acknowledge in the same cycle as doneValid. A slave model in the bench records SDA at every SCL rise, measures each high phase and counts start and stop conditions. Each command is therefore judged on its pin waveform as well as on its result.

// File: rtl/i2cBitPkg.sv
package i2cBitPkg;

  localparam logic [2:0] CODE_RECOVER = 3'd1;
  localparam logic [2:0] CODE_START   = 3'd2;
  localparam logic [2:0] CODE_STOP    = 3'd3;
  localparam logic [2:0] CODE_TX      = 3'd4;
  localparam logic [2:0] CODE_RX      = 3'd5;

  typedef enum logic [1:0] {
    SDA_RELEASE,
    SDA_LOW,
    SDA_DATA,
    SDA_ACKBIT
  } sdaSrc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECOVER,
    ST_START,
    ST_STOP,
    ST_TX,
    ST_RX,
    ST_NOP
  } state_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    load;        // command accepted this cycle
    logic    ackFromCmd;  // preset ack register from cmdAck
    logic    sclSet;
    logic    sclRelease;
    logic    sdaSet;
    sdaSrc_e sdaSrc;
    logic    shiftOut;
    logic    sampleData;
    logic    sampleAck;
    logic    finish;
  } strobe_t;

endpackage

// File: rtl/i2cBitCtrl.sv
module i2cBitCtrl
  import i2cBitPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int RECOVER_PULSES = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       unitTick,
  output logic       cmdReady,
  output strobe_t    stb
);

  localparam int MAX_SLOT = (DATA_W > RECOVER_PULSES) ? DATA_W : RECOVER_PULSES;
  localparam int CNT_W    = $clog2(MAX_SLOT + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(RECOVER_PULSES - 1);

  state_e           st, stN;
  logic [2:0]       ph, phN;
  logic [CNT_W-1:0] bitIdx, bitN;
  logic             accept, enter, fin;

  assign cmdReady = (st == ST_IDLE);
  assign accept   = cmdValid && cmdReady;

  // next step selection
  always_comb begin
    stN   = st;
    phN   = ph;
    bitN  = bitIdx;
    enter = 1'b0;
    fin   = 1'b0;
    if (st == ST_IDLE) begin
      if (cmdValid) begin
        enter = 1'b1;
        phN   = '0;
        bitN  = '0;
        case (cmdCode)
          CODE_RECOVER: stN = ST_RECOVER;
          CODE_START:   stN = ST_START;
          CODE_STOP:    stN = ST_STOP;
          CODE_TX:      stN = ST_TX;
          CODE_RX:      stN = ST_RX;
          default:      stN = ST_NOP;
        endcase
      end
    end else if (unitTick) begin
      enter = 1'b1;
      case (st)
        ST_RECOVER: begin
          if (ph == 3'd3) begin
            phN = '0;
            if (bitIdx == LAST_PULSE) begin
              stN  = ST_STOP;
              bitN = '0;
            end else begin
              bitN = bitIdx + 1'b1;
            end
          end else begin
            phN = ph + 3'd1;
          end
        end
        ST_START, ST_STOP: begin
          if (ph == 3'd3) begin
            fin = 1'b1;
          end else begin
            phN = ph + 3'd1;
          end
        end
        ST_TX: begin
          if (bitIdx == ACK_SLOT) begin
            if (ph == 3'd4) fin = 1'b1;
            else            phN = ph + 3'd1;
          end else if (ph == 3'd3) begin
            phN  = '0;
            bitN = bitIdx + 1'b1;
          end else begin
            phN = ph + 3'd1;
          end
        end
        ST_RX: begin
          if (bitIdx == ACK_SLOT) begin
            if (ph == 3'd4) fin = 1'b1;
            else            phN = ph + 3'd1;
          end else if (ph == 3'd2) begin
            phN  = '0;
            bitN = bitIdx + 1'b1;
          end else begin
            phN = ph + 3'd1;
          end
        end
        default: fin = 1'b1;
      endcase
      if (fin) begin
        enter = 1'b0;
        stN   = ST_IDLE;
        phN   = '0;
        bitN  = '0;
      end
    end
  end

  // line actions applied on entry to each step
  always_comb begin
    logic ackSlot;
    ackSlot        = (bitN == ACK_SLOT);
    stb            = '0;
    stb.load       = accept;
    stb.ackFromCmd = accept && (cmdCode == CODE_RX);
    stb.finish     = fin;
    if (enter) begin
      case (stN)
        ST_RECOVER: begin
          if (phN == 3'd0) begin
            stb.sclSet = 1'b1;
            stb.sdaSet = 1'b1;
            stb.sdaSrc = SDA_RELEASE;
          end else if (phN == 3'd2) begin
            stb.sclSet     = 1'b1;
            stb.sclRelease = 1'b1;
          end
        end
        ST_START: begin
          if (phN == 3'd1) begin
            stb.sdaSet = 1'b1;
            stb.sdaSrc = SDA_RELEASE;
          end else if (phN == 3'd2) begin
            stb.sclSet     = 1'b1;
            stb.sclRelease = 1'b1;
          end else if (phN == 3'd3) begin
            stb.sdaSet = 1'b1;
            stb.sdaSrc = SDA_LOW;
          end
        end
        ST_STOP: begin
          if (phN == 3'd0) begin
            stb.sclSet = 1'b1;
          end else if (phN == 3'd1) begin
            stb.sdaSet = 1'b1;
            stb.sdaSrc = SDA_LOW;
          end else if (phN == 3'd2) begin
            stb.sclSet     = 1'b1;
            stb.sclRelease = 1'b1;
          end else if (phN == 3'd3) begin
            stb.sdaSet = 1'b1;
            stb.sdaSrc = SDA_RELEASE;
          end
        end
        ST_TX: begin
          if (phN == 3'd0) begin
            stb.sclSet = 1'b1;
          end else if (phN == 3'd1) begin
            stb.sdaSet   = 1'b1;
            stb.sdaSrc   = ackSlot ? SDA_RELEASE : SDA_DATA;
            stb.shiftOut = !ackSlot;
          end else if (phN == 3'd2) begin
            stb.sclSet     = 1'b1;
            stb.sclRelease = 1'b1;
          end else if (phN == 3'd4) begin
            stb.sampleAck = 1'b1;
            stb.sclSet    = 1'b1;
          end
        end
        ST_RX: begin
          if (phN == 3'd0) begin
            stb.sclSet = 1'b1;
            stb.sdaSet = !ackSlot;
            stb.sdaSrc = SDA_RELEASE;
          end else if (phN == 3'd1) begin
            if (ackSlot) begin
              stb.sdaSet = 1'b1;
              stb.sdaSrc = SDA_ACKBIT;
            end else begin
              stb.sclSet     = 1'b1;
              stb.sclRelease = 1'b1;
            end
          end else if (phN == 3'd2) begin
            if (ackSlot) begin
              stb.sclSet     = 1'b1;
              stb.sclRelease = 1'b1;
            end else begin
              stb.sampleData = 1'b1;
            end
          end else if (phN == 3'd4) begin
            stb.sclSet = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      ph     <= '0;
      bitIdx <= '0;
    end else begin
      st     <= stN;
      ph     <= phN;
      bitIdx <= bitN;
    end
  end

  // R2: once accepted, the engine is busy on the next cycle
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R3: completion only lands on a unit boundary from the timer
  assert_finish_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> unitTick);

endmodule

// File: rtl/i2cBitDatapath.sv
module i2cBitDatapath
  import i2cBitPkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [DATA_W-1:0]  cmdByte,
  input  logic               cmdAck,
  input  logic               sdaIn,
  input  strobe_t            stb,
  output logic               unitTick,
  output logic               sclPull,
  output logic               sdaPull,
  output logic [DATA_W-1:0]  rxByte,
  output logic               ackLevel,
  output logic               doneValid
);

  logic [PRESC_W-1:0] unitLenNow, unitLenQ, cntQ;
  logic               running;
  logic [DATA_W-1:0]  shiftQ;
  logic               ackQ;
  logic               sdaSync;

  // input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= sdaIn;
      end
      assign sdaSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
      end
      assign sdaSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // delay-unit timer
  assign unitLenNow = (prescale == '0) ? PRESC_W'(1) : prescale;
  assign unitTick   = running && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitLenQ <= PRESC_W'(1);
      cntQ     <= '0;
      running  <= 1'b0;
    end else if (stb.load) begin
      unitLenQ <= unitLenNow;
      cntQ     <= unitLenNow - 1'b1;
      running  <= 1'b1;
    end else if (stb.finish) begin
      running  <= 1'b0;
    end else if (running) begin
      cntQ     <= (cntQ == '0) ? unitLenQ - 1'b1 : cntQ - 1'b1;
    end
  end

  // shift register and acknowledge bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      ackQ   <= 1'b0;
    end else begin
      if (stb.load)            shiftQ <= cmdByte;
      else if (stb.shiftOut)   shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};
      else if (stb.sampleData) shiftQ <= {shiftQ[DATA_W-2:0], sdaSync};
      if (stb.load)            ackQ <= stb.ackFromCmd ? cmdAck : 1'b0;
      else if (stb.sampleAck)  ackQ <= sdaSync;
    end
  end

  // open-drain line registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPull <= 1'b0;
      sdaPull <= 1'b0;
    end else begin
      if (stb.sclSet) sclPull <= !stb.sclRelease;
      if (stb.sdaSet) begin
        case (stb.sdaSrc)
          SDA_RELEASE: sdaPull <= 1'b0;
          SDA_LOW:     sdaPull <= 1'b1;
          SDA_DATA:    sdaPull <= !shiftQ[DATA_W-1];
          SDA_ACKBIT:  sdaPull <= !ackQ;
          default:     sdaPull <= 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneValid <= 1'b0;
    else       doneValid <= stb.finish;
  end

  assign rxByte   = shiftQ;
  assign ackLevel = ackQ;

  // R11: completion pulse is one cycle wide
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R11: completion only follows a finish step
  assert_done_after_finish_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(stb.finish));

  // R7: data or ack bits are placed on SDA only while SCL is held low
  assert_sda_moves_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sdaSet && (stb.sdaSrc == SDA_DATA || stb.sdaSrc == SDA_ACKBIT)) |-> sclPull);

  // R3: SCL holds between step boundaries
  assert_scl_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sclSet |=> $stable(sclPull));

endmodule

// File: rtl/i2cBitEngine.sv
module i2cBitEngine
  import i2cBitPkg::*;
#(
  parameter int PRESC_W        = 16,
  parameter int DATA_W         = 8,
  parameter int RECOVER_PULSES = 9,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [2:0]         cmdCode,
  input  logic [DATA_W-1:0]  cmdByte,
  input  logic               cmdAck,
  output logic               doneValid,
  output logic [DATA_W-1:0]  rxByte,
  output logic               ackLevel,
  input  logic               sdaIn,
  output logic               sclPull,
  output logic               sdaPull
);

  strobe_t stb;
  logic    unitTick;

  i2cBitCtrl #(
    .DATA_W        (DATA_W),
    .RECOVER_PULSES(RECOVER_PULSES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .unitTick (unitTick),
    .cmdReady (cmdReady),
    .stb      (stb)
  );

  i2cBitDatapath #(
    .PRESC_W    (PRESC_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .prescale (prescale),
    .cmdByte  (cmdByte),
    .cmdAck   (cmdAck),
    .sdaIn    (sdaIn),
    .stb      (stb),
    .unitTick (unitTick),
    .sclPull  (sclPull),
    .sdaPull  (sdaPull),
    .rxByte   (rxByte),
    .ackLevel (ackLevel),
    .doneValid(doneValid)
  );

endmodule

// File: tb/test_i2cBitEngine.sv
module test_i2cBitEngine;

  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] prescale = '0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [2:0]    cmdCode = '0;
  logic [7:0]    cmdByte = '0;
  logic          cmdAck = 1'b0;
  logic          doneValid;
  logic [7:0]    rxByte;
  logic          ackLevel;
  logic          sdaIn;
  logic          sclPull, sdaPull;
  logic          slavePull = 1'b0;

  always #5 clk = ~clk;

  assign sdaIn = !(sdaPull || slavePull);

  i2cBitEngine #(.PRESC_W(PW)) i_i2cBitEngine (
    .clk(clk), .rstN(rstN), .prescale(prescale), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdCode(cmdCode), .cmdByte(cmdByte), .cmdAck(cmdAck),
    .doneValid(doneValid), .rxByte(rxByte), .ackLevel(ackLevel), .sdaIn(sdaIn),
    .sclPull(sclPull), .sdaPull(sdaPull)
  );

  typedef struct {
    int code;
    int unitLen;
    int cycles;
    int rises;   // -1: not checked
    int bits;
    int starts;
    int stops;
    int ack;
    int rxData;  // -1: not checked
  } item_t;

  item_t expQ[$];
  int vectors = 0, fails = 0;
  int cyc = 0;

  // slave model controls
  int         slaveMode = 0;  // 0 idle, 1 ack a transmit, 2 send a byte
  logic       slaveAck = 1'b0;
  logic [7:0] slaveData = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int code);
    case (code)
      1: return "R6";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      5: return "R10";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) cyc++;

  // bus monitor, slave model and result scoreboard
  bit inCmd = 0, highOwned = 0, lastDone = 0;
  int acceptCyc = 0, rises = 0, starts = 0, stops = 0, widthErr = 0, readyErr = 0;
  int riseCyc = 0, curUnit = 1;
  logic [8:0] bitsSeen = '0;
  logic prevScl = 1'b1, prevSda = 1'b1;

  always @(negedge clk) begin
    logic sclCur, sdaCur;
    item_t it;
    sclCur = !sclPull;
    sdaCur = sdaIn;
    if (rstN) begin
      if (prevScl && sclCur && prevSda && !sdaCur) starts++;
      if (prevScl && sclCur && !prevSda && sdaCur) stops++;
      if (!prevScl && sclCur) begin
        if (rises < 9) bitsSeen = {bitsSeen[7:0], sdaCur};
        rises++;
        riseCyc   = cyc;
        highOwned = inCmd;
      end
      if (prevScl && !sclCur && highOwned) begin
        if (cyc - riseCyc != 2 * curUnit) widthErr++;
        highOwned = 0;
      end
      if (inCmd && !doneValid && cmdReady) readyErr++;
      if (lastDone) check(!doneValid, "R11", "done width", doneValid, 0);
      if (doneValid) begin
        if (expQ.size() == 0) begin
          check(0, "R11", "unexpected done", 1, 0);
        end else begin
          it = expQ.pop_front();
          check(cyc - acceptCyc == it.cycles, "R3", "cycles to done", cyc - acceptCyc, it.cycles);
          check(starts == it.starts, reqOf(it.code), "start conditions", starts, it.starts);
          check(stops == it.stops, reqOf(it.code), "stop conditions", stops, it.stops);
          check(readyErr == 0, "R2", "ready while busy", readyErr, 0);
          check(cmdReady, "R2", "ready at done", cmdReady, 1);
          check(ackLevel == it.ack, reqOf(it.code), "ack level", ackLevel, it.ack);
          if (it.rises >= 0) begin
            check(rises == it.rises, reqOf(it.code), "SCL pulses", rises, it.rises);
            if (it.rises > 0) begin
              check(bitsSeen == it.bits[8:0], it.code == 4 ? "R7" : (it.code == 5 ? "R9" : "R6"),
                    "SDA at SCL rises", bitsSeen, it.bits);
              check(widthErr == 0, it.code == 5 ? "R9" : (it.code == 4 ? "R7" : "R6"),
                    "SCL high width errors", widthErr, 0);
            end
          end
          if (it.rxData >= 0) check(rxByte == it.rxData[7:0], "R9", "received byte", rxByte, it.rxData);
          if (it.code != 1 && it.code != 2 && it.code != 3 && it.code != 4 && it.code != 5)
            check(sclPull == 0 && sdaPull == 0, "R12", "lines untouched", {sclPull, sdaPull}, 0);
        end
        inCmd = 0;
      end
      lastDone = doneValid;
      if (cmdValid && cmdReady) begin
        inCmd     = 1;
        acceptCyc = cyc + 1;
        rises = 0; starts = 0; stops = 0; widthErr = 0; readyErr = 0;
        highOwned = 0;
        bitsSeen  = '0;
        curUnit   = (expQ.size() > 0) ? expQ[0].unitLen : 1;
      end
      if (!sclCur) begin
        case (slaveMode)
          1: slavePull = (rises == 8) && slaveAck;
          2: slavePull = (rises < 8) && !slaveData[7 - rises];
          default: slavePull = 1'b0;
        endcase
      end
    end
    prevScl = sclCur;
    prevSda = sdaCur;
  end

  task automatic runCmd(input int code, input int presc, input logic [7:0] byteV,
                        input logic ackV, input int mode, input logic sAck,
                        input logic [7:0] sData);
    item_t it;
    int L;
    L = (presc == 0) ? 1 : presc;
    it.code = code; it.unitLen = L; it.rises = -1; it.bits = 0;
    it.starts = 0; it.stops = 0; it.ack = 0; it.rxData = -1;
    case (code)
      1: begin it.cycles = 40 * L; it.rises = 10; it.bits = 9'h1FF; it.stops = 1; end
      2: begin it.cycles = 4 * L; it.starts = 1; end
      3: begin it.cycles = 4 * L; it.stops = 1; end
      4: begin
        it.cycles = 37 * L; it.rises = 9; it.ack = sAck ? 0 : 1;
        it.bits = {byteV, !sAck};
      end
      5: begin
        it.cycles = 29 * L; it.rises = 9; it.ack = ackV;
        it.bits = {sData, ackV}; it.rxData = sData;
      end
      default: begin it.cycles = L; it.rises = 0; end
    endcase
    expQ.push_back(it);
    @(posedge clk); #2;
    slaveMode = mode; slaveAck = sAck; slaveData = sData;
    prescale = PW'(presc); cmdCode = code[2:0]; cmdByte = byteV; cmdAck = ackV;
    cmdValid = 1'b1;
    @(posedge clk); #2;
    cmdValid = 1'b0;
    while (expQ.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sclPull == 0, "R1", "sclPull after reset", sclPull, 0);
    check(sdaPull == 0, "R1", "sdaPull after reset", sdaPull, 0);
    check(cmdReady == 1, "R1", "ready after reset", cmdReady, 1);
    check(doneValid == 0, "R1", "done after reset", doneValid, 0);

    runCmd(1, 2, 8'h00, 0, 0, 0, 8'h00);     // R6 recovery
    runCmd(2, 3, 8'h00, 0, 0, 0, 8'h00);     // R4 start from idle
    runCmd(4, 3, 8'hA5, 0, 1, 1, 8'h00);     // R7 R8 transmit, acknowledged
    runCmd(5, 2, 8'h00, 0, 2, 0, 8'h96);     // R9 R10 receive, continue
    runCmd(5, 3, 8'h00, 1, 2, 0, 8'h4B);     // R9 R10 receive, end
    runCmd(3, 0, 8'h00, 0, 0, 0, 8'h00);     // R5 stop, prescale 0 counts as 1 (R3)
    runCmd(2, 0, 8'h00, 0, 0, 0, 8'h00);     // R4 start, R3 zero prescale
    runCmd(4, 2, 8'h3C, 0, 1, 0, 8'h00);     // R8 transmit, not acknowledged
    runCmd(2, 2, 8'h00, 0, 0, 0, 8'h00);     // R4 repeated start
    runCmd(4, 4, 8'h01, 0, 1, 1, 8'h00);     // R7 single low-order one
    runCmd(3, 5, 8'h00, 0, 0, 0, 8'h00);     // R5 stop
    runCmd(0, 2, 8'hFF, 1, 0, 0, 8'h00);     // R12 unused code
    runCmd(7, 4, 8'h00, 1, 0, 0, 8'h00);     // R12 unused code

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule